// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional ports, called A and B, and carries data across in one direction at a time. Each port owns a holding register. The port being driven can show either the live value on the opposite port (pass-through) or the value last captured from it (stored). Each port is split into separate input, output and output-enable signals, so that the pad ring or a simulation model can resolve the tri-state pins.

Three controls set the behaviour. An active-low output enable and a direction bit pick one of three modes, each decoded combinationally:

- **ISOLATE**: the enable is high, so neither port is driven.
- **A2B**: the enable is low and the direction bit is high, so B is driven from the A side.
- **B2A**: the enable is low and the direction bit is low, so A is driven from the B side.

Any change of the enable or the direction bit moves the block to the matching mode within the same cycle.

Each direction also has a strobe input that serves as both clock and select. The strobe is sampled on the system clock. When it rises, its register captures the port data. While the strobe is high, the driven port shows stored data; while it is low, the driven port shows live data. Each lane has a two-state edge tracker, LOW and HIGH. A LOW-to-HIGH step is a capture. A synchronous active-low reset clears both registers and keeps both ports undriven while reset is applied.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Reset clears both registers to zero. If a strobe is held high across the release of reset, no capture occurs and the storage view shows zero.
- R2: While rst_n is low, a_oe and b_oe are both 0.
- R3: When oe_n is 1, a_oe and b_oe are both 0 and a_out and b_out are both zero. Any undriven port output reads zero.
- R4: When oe_n is 0 and dir is 1, b_oe is 1 and a_oe is 0. When oe_n is 0 and dir is 0, a_oe is 1 and b_oe is 0. The two enables are never 1 together.
- R5: If sel_ab is 0 while B is driven, b_out equals a_in in the same cycle. If sel_ba is 0 while A is driven, a_out equals b_in in the same cycle.
- R6: A clock edge at which a strobe is 1 and was 0 at the previous edge loads that lane's register from its input port (sel_ab loads from a_in, sel_ba loads from b_in). While the strobe stays 1, the driven port shows the register contents.
- R7: In the cycle in which a strobe rises, the driven port already shows the value being captured, which is the live input, so the output does not change at the switch to stored mode.
- R8: Capture depends only on the strobes. It works in ISOLATE and in either transceiver mode, and both lanes may capture in the same cycle.
- R9: A register keeps its value while its strobe stays high or low, and across any change of oe_n or dir.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir | input | 1 | 1 drives B from A, 0 drives A from B |
| sel_ab | input | 1 | A-lane strobe: its rise captures a_in; a high level selects stored data onto B |
| sel_ba | input | 1 | B-lane strobe: its rise captures b_in; a high level selects stored data onto A |
| a_in | input | 8 | Value present on the A pins |
| a_out | output | 8 | Value driven onto the A pins, zero when not driven |
| a_oe | output | 1 | Drive enable for the A pins |
| b_in | input | 8 | Value present on the B pins |
| b_out | output | 8 | Value driven onto the B pins, zero when not driven |
| b_oe | output | 1 | Drive enable for the B pins |

## Verification
The bench steps through a long arithmetic sweep of every combination of the four controls, with changing data. Strobe rises therefore occur in every mode, including both lanes at once during isolation. A design that lagged its register by one clock would show the previous capture in the rise cycle and glitch the output, which the R7 checks would report. A design that recaptured on a level instead of an edge would lose the stored word while the live data moved, which the R9 checks would report. Directed steps hold a strobe high across the release of reset, which exposes any false capture at the first edge. They also load both registers while isolated and then read each one back in its transceiver mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_A2B     = 2'd1,
        MODE_B2A     = 2'd2
    } xcvr_mode_e;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_e;
endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] view
);
    edge_state_e  state_q;
    logic         rise;
    logic [W-1:0] held;

    // Edge tracker follows the strobe level; during reset it tracks too,
    // so a strobe held high across reset release causes no capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= strobe ? EDGE_HIGH : EDGE_LOW;
            held    <= '0;
        end else begin
            state_q <= strobe ? EDGE_HIGH : EDGE_LOW;
            if (rise) held <= d_in;
        end
    end

    always_comb begin
        unique case (state_q)
            EDGE_LOW:  rise = strobe;
            EDGE_HIGH: rise = 1'b0;
            default:   rise = 1'b0;
        endcase
        view = rise ? d_in : held;
    end

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (held == $past(d_in)));

    assert_retain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(held));
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_pkg::*;
(
    input  logic       rst_n,
    input  logic       oe_n,
    input  logic       dir,
    output xcvr_mode_e mode,
    output logic       a_oe,
    output logic       b_oe
);
    always_comb begin
        if (!rst_n || oe_n) mode = MODE_ISOLATE;
        else if (dir)       mode = MODE_A2B;
        else                mode = MODE_B2A;
    end

    always_comb begin
        unique case (mode)
            MODE_ISOLATE: begin a_oe = 1'b0; b_oe = 1'b0; end
            MODE_A2B:     begin a_oe = 1'b0; b_oe = 1'b1; end
            MODE_B2A:     begin a_oe = 1'b1; b_oe = 1'b0; end
            default:      begin a_oe = 1'b0; b_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    localparam logic [W-1:0] IDLE_WORD = '0;

    xcvr_mode_e   mode;
    logic [W-1:0] a_view;
    logic [W-1:0] b_view;
    logic [W-1:0] to_b;
    logic [W-1:0] to_a;

    xcvr_hold_reg #(.W(W)) u_hold_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (sel_ab),
        .d_in   (a_in),
        .view   (a_view)
    );

    xcvr_hold_reg #(.W(W)) u_hold_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (sel_ba),
        .d_in   (b_in),
        .view   (b_view)
    );

    xcvr_dir_ctrl u_ctl (
        .rst_n (rst_n),
        .oe_n  (oe_n),
        .dir   (dir),
        .mode  (mode),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    always_comb begin
        to_b = sel_ab ? a_view : a_in;
        to_a = sel_ba ? b_view : b_in;
        unique case (mode)
            MODE_A2B: begin b_out = to_b;      a_out = IDLE_WORD; end
            MODE_B2A: begin b_out = IDLE_WORD; a_out = to_a;      end
            default:  begin b_out = IDLE_WORD; a_out = IDLE_WORD; end
        endcase
    end

    always @(posedge clk) begin
        if (rst_n == 1'b0) begin
            assert_quiet_in_reset_R2: assert (!a_oe && !b_oe);
        end
    end

    assert_isolate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    assert_pass_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> (b_out == a_in));

    assert_pass_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> (a_out == b_in));

    assert_seamless_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && $rose(sel_ab)) |-> (b_out == a_in));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [W-1:0] ra = '0, rb = '0;
    logic pab = 1'b0, pba = 1'b0;

    bus_xcvr_reg #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic o, input logic d, input logic sab, input logic sba,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        oe_n = o; dir = d; sel_ab = sab; sel_ba = sba; a_in = a; b_in = b;
        #1;
    endtask

    // expected port state from the requirements and the bench's own model
    task automatic check_all();
        logic eb, ea;
        logic [W-1:0] vb, va, xb, xa;
        string tg, tb_tag, ta_tag;
        eb = rst_n && !oe_n && dir;
        ea = rst_n && !oe_n && !dir;
        tg = !rst_n ? "R2" : (oe_n ? "R3" : "R4");
        chk(tg, 32'(b_oe), 32'(eb));
        chk(tg, 32'(a_oe), 32'(ea));
        if (!rst_n) return;
        vb = (sel_ab && !pab) ? a_in : ra;
        va = (sel_ba && !pba) ? b_in : rb;
        xb = eb ? (sel_ab ? vb : a_in) : '0;
        xa = ea ? (sel_ba ? va : b_in) : '0;
        tb_tag = !eb ? "R3" : (!sel_ab ? "R5" : (!pab ? "R7" : "R6"));
        ta_tag = !ea ? "R3" : (!sel_ba ? "R5" : (!pba ? "R7" : "R6"));
        chk(tb_tag, 32'(b_out), 32'(xb));
        chk(ta_tag, 32'(a_out), 32'(xa));
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            ra = '0; rb = '0;
        end else begin
            if (sel_ab && !pab) ra = a_in;
            if (sel_ba && !pba) rb = b_in;
        end
        pab = sel_ab;
        pba = sel_ba;
    endtask

    task automatic finish_up();
        if (done) return;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        // reset with both strobes held high and a transceiver mode requested
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h33, 8'h44);
            check_all();  // R2
            tick();
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", 32'(b_out), 32'h0);
        check_all();
        tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'h66);
        chk("R1", 32'(a_out), 32'h0);
        check_all();
        tick();

        // sweep of all control combinations with moving data
        for (int i = 0; i < 1024; i++) begin
            drive(i[3], i[2], i[1] ^ i[5], i[0] ^ i[6], W'(i * 37 + 5), W'(i * 91 + 13));
            check_all();
            tick();
        end

        // R8: both lanes capture together while isolated
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        check_all();
        tick();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3);
        chk("R8", 32'(b_oe), 32'h0);
        check_all();
        tick();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
        chk("R8", 32'(b_out), 32'h5A);
        check_all();
        tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88);
        chk("R8", 32'(a_out), 32'hC3);
        check_all();
        tick();
        // R9: level-high strobe and mode changes leave the stored words intact
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h99, 8'hAA);
        check_all();
        tick();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hE1, 8'hE2);
        chk("R9", 32'(b_out), 32'h5A);
        check_all();
        tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'hF1, 8'hF2);
        chk("R9", 32'(a_out), 32'hC3);
        check_all();
        tick();
        // R7: a fresh rise in transceiver mode shows the live word at once
        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
        chk("R5", 32'(b_out), 32'h3C);
        tick();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h6B, 8'h00);
        chk("R7", 32'(b_out), 32'h6B);
        tick();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 8'h00);
        chk("R6", 32'(b_out), 32'h6B);
        check_all();
        tick();

        finish_up();
    end
endmodule